// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block is the transfer engine of a four-channel DMA controller. It holds a single state machine that picks one channel to serve, waits until that channel is enabled and holds a non-zero byte count, and then asks the processor for the bus. It uses one of two request lines, chosen by the channel's transfer mode. Once the bus is granted it moves one byte per grant cycle. On each such cycle it reports the new address and count, which are written back to the channel's registers. It pulses a completion flag when the last byte has gone.

The channel registers live outside this block. The surrounding register file presents each channel's address, byte count and control nibble on flat buses. It stores `upd_addr`/`upd_count` into the acknowledged channel on every cycle where `ack_valid` is high, and it sets that channel's end flag when `done` is high. The interrupt logic and the host register decode are also outside this block. Arbitration is either fixed or rotating. In fixed mode channel 0 is strongest and channel 3 weakest. In rotating mode the channel served most recently becomes the weakest.

Top module: `dma_seq`

## Requirements
- R1: After reset both bus-request outputs, `ack_valid`, `done` and all four strobes are low. The internal last-served channel starts at 3.
- R2: With `rotate` low, among channels that are enabled and requesting, the one with the lowest index is served first.
- R3: With `rotate` high, the scan starts at the channel after the last one served, wrapping from 3 to 0. The channel just served therefore has the lowest priority.
- R4: A selected channel raises no bus request and moves no byte while its byte count is zero or its enable bit is low. Once both conditions are met it proceeds.
- R5: The control nibble is laid out as bit 0 direction, bits 2:1 mode, bit 3 address-down. Once the channel requests, mode 00 (halt steal) and mode 01 (block) raise `bus_req_halt`, mode 10 (three-state steal) raises `bus_req_tsc`, and mode 11 raises neither. The two request lines are never high together.
- R6: A byte moves only in a cycle where `grant` and the served channel's request are both high. That cycle has `ack_valid` high and `ack_chan` set to the channel number.
- R7: On a move, `mem_addr` equals the channel address. With direction 0, `dev_rd` and `mem_wr` pulse. With direction 1, `mem_rd` and `dev_wr` pulse. All strobes are low when no byte moves.
- R8: On a move, `upd_count` is the count minus one. `upd_addr` is the address minus one when the down bit is 1, and plus one otherwise. A channel moves exactly as many bytes as its starting count.
- R9: The move that brings the count to zero pulses `done`. Both request lines are low in the next cycle, and the machine returns to arbitration.
- R10: After a byte that is not the last one, halt-steal mode drops `bus_req_halt` for the next cycle and three-state mode drops `bus_req_tsc` for the next cycle. Block mode keeps `bus_req_halt` high and moves the next byte in the very next cycle if the grant is still present.
- R11: In mode 11, after each byte both request lines stay low and the next cycle moves no byte, because the machine goes back through arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | NCH | Per-channel enable bits |
| rotate | input | 1 | 1 selects rotating priority, 0 selects fixed |
| xfer_req | input | NCH | Per-channel transfer requests |
| grant | input | 1 | Bus grant from the processor |
| ch_addr | input | NCH*AW | Channel addresses, channel i at [i*AW +: AW] |
| ch_count | input | NCH*CW | Channel byte counts, channel i at [i*CW +: CW] |
| ch_ctrl | input | NCH*4 | Channel control nibbles (bit 0 direction, 2:1 mode, 3 down) |
| bus_req_tsc | output | 1 | Bus request for three-state steal mode |
| bus_req_halt | output | 1 | Bus request for halt steal and block modes |
| ack_valid | output | 1 | A byte moves this cycle; write-back enable |
| ack_chan | output | $clog2(NCH) | Channel being served |
| mem_addr | output | AW | Memory address of the byte |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| upd_addr | output | AW | Address to write back |
| upd_count | output | CW | Count to write back |
| done | output | 1 | Last byte of the channel moves this cycle |

## Verification
Suppose the served-channel register or the last-served register is wrong. Then the first byte after arbitration carries an unexpected `ack_chan`, or the completion order differs from the order predicted by the priority rule, and this shows within four cycles of the requests rising. Suppose instead the state register goes astray. That shows on the bus-request lines in the cycle right after a byte: a line that should drop stays high, block mode misses a back-to-back byte, or mode 11 moves a byte without passing back through arbitration. Errors in the address step or the count show on `upd_addr`/`upd_count` in the same cycle as the byte. They also build up into a wrong byte total for the channel.

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           chan_en,
  input  logic                     rotate,
  input  logic [NCH-1:0]           xfer_req,
  input  logic                     grant,
  input  logic [NCH*AW-1:0]        ch_addr,
  input  logic [NCH*CW-1:0]        ch_count,
  input  logic [NCH*4-1:0]         ch_ctrl,
  output logic                     bus_req_tsc,
  output logic                     bus_req_halt,
  output logic                     ack_valid,
  output logic [$clog2(NCH)-1:0]   ack_chan,
  output logic [AW-1:0]            mem_addr,
  output logic                     mem_wr,
  output logic                     mem_rd,
  output logic                     dev_rd,
  output logic                     dev_wr,
  output logic [AW-1:0]            upd_addr,
  output logic [CW-1:0]            upd_count,
  output logic                     done
);
  localparam int CHW = $clog2(NCH);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  typedef enum logic [1:0] {ST_ARB, ST_CNT, ST_REQ, ST_MOVE} st_t;
  st_t st;

  logic [CHW-1:0] cur, last;
  logic [AW-1:0]  c_addr;
  logic [CW-1:0]  c_cnt;
  logic [3:0]     c_ctl;
  logic [1:0]     mode;
  logic           xfer, last_byte;

  assign c_addr = ch_addr[int'(cur)*AW +: AW];
  assign c_cnt  = ch_count[int'(cur)*CW +: CW];
  assign c_ctl  = ch_ctrl[int'(cur)*4 +: 4];
  assign mode   = c_ctl[2:1];

  assign xfer      = (st == ST_MOVE) && grant && xfer_req[cur];
  assign ack_valid = xfer;
  assign ack_chan  = cur;
  assign mem_addr  = c_addr;
  assign mem_wr    = xfer && !c_ctl[0];
  assign dev_rd    = xfer && !c_ctl[0];
  assign mem_rd    = xfer && c_ctl[0];
  assign dev_wr    = xfer && c_ctl[0];
  assign upd_addr  = c_ctl[3] ? c_addr - 1'b1 : c_addr + 1'b1;
  assign upd_count = c_cnt - 1'b1;
  assign last_byte = (upd_count == '0);
  assign done      = xfer && last_byte;

  logic [NCH-1:0] cand;
  logic [CHW-1:0] start, pick;
  logic           found;

  assign cand = chan_en & xfer_req;

  always_comb begin
    start = (!rotate || last == LAST_CH) ? '0 : last + 1'b1;
    found = 1'b0;
    pick  = start;
    for (int i = 0; i < NCH; i++) begin
      if (!found && cand[(int'(start) + i) % NCH]) begin
        found = 1'b1;
        pick  = CHW'((int'(start) + i) % NCH);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_ARB;
      cur          <= LAST_CH;
      last         <= LAST_CH;
      bus_req_tsc  <= 1'b0;
      bus_req_halt <= 1'b0;
    end else begin
      case (st)
        ST_ARB: if (found) begin
          cur  <= pick;
          last <= pick;
          st   <= ST_CNT;
        end
        ST_CNT: if (chan_en[cur] && c_cnt != '0) st <= ST_REQ;
        ST_REQ: if (xfer_req[cur]) begin
          st <= ST_MOVE;
          case (mode)
            2'b00, 2'b01: bus_req_halt <= 1'b1;
            2'b10:        bus_req_tsc  <= 1'b1;
            default: begin
              bus_req_halt <= 1'b0;
              bus_req_tsc  <= 1'b0;
            end
          endcase
        end
        ST_MOVE: if (xfer) begin
          if (last_byte) begin
            bus_req_halt <= 1'b0;
            bus_req_tsc  <= 1'b0;
            st           <= ST_ARB;
          end else begin
            case (mode)
              2'b00: begin bus_req_halt <= 1'b0; st <= ST_REQ; end
              2'b01: st <= ST_MOVE;
              2'b10: begin bus_req_tsc <= 1'b0; st <= ST_REQ; end
              default: begin
                bus_req_halt <= 1'b0;
                bus_req_tsc  <= 1'b0;
                st           <= ST_ARB;
              end
            endcase
          end
        end
        default: st <= ST_ARB;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         xfer_req,
  input logic                   grant,
  input logic [NCH*4-1:0]       ch_ctrl,
  input logic                   bus_req_tsc,
  input logic                   bus_req_halt,
  input logic                   ack_valid,
  input logic [$clog2(NCH)-1:0] ack_chan,
  input logic [AW-1:0]          mem_addr,
  input logic                   mem_wr,
  input logic                   mem_rd,
  input logic                   dev_rd,
  input logic                   dev_wr,
  input logic [AW-1:0]          upd_addr,
  input logic [CW-1:0]          upd_count,
  input logic                   done
);
  logic [3:0] ack_ctl;
  assign ack_ctl = ch_ctrl[int'(ack_chan)*4 +: 4];

  p_drq_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req_tsc && bus_req_halt));

  p_ack_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (grant && xfer_req[ack_chan]));

  p_dir_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (mem_wr == !ack_ctl[0]) && (dev_rd == !ack_ctl[0]) &&
                  (mem_rd == ack_ctl[0]) && (dev_wr == ack_ctl[0]));

  p_quiet_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> !(mem_wr || mem_rd || dev_rd || dev_wr || done));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (upd_addr == (ack_ctl[3] ? AW'(mem_addr - 1'b1) : AW'(mem_addr + 1'b1))));

  p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (upd_count == '0));

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!bus_req_tsc && !bus_req_halt));

  p_halt_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !done && ack_ctl[2:1] == 2'b00) |=> !bus_req_halt);

  p_tsc_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !done && ack_ctl[2:1] == 2'b10) |=> !bus_req_tsc);

  p_undef_rearb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ctl[2:1] == 2'b11) |=> (!ack_valid && !bus_req_tsc && !bus_req_halt));
endmodule

bind dma_seq dma_seq_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .grant(grant), .ch_ctrl(ch_ctrl),
  .bus_req_tsc(bus_req_tsc), .bus_req_halt(bus_req_halt), .ack_valid(ack_valid),
  .ack_chan(ack_chan), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
  .dev_rd(dev_rd), .dev_wr(dev_wr), .upd_addr(upd_addr), .upd_count(upd_count),
  .done(done)
);

// File: tb/dma_seq_test.sv
module dma_seq_test;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic rotate = 1'b0;
  logic grant = 1'b0;
  logic [NCH-1:0] req;
  logic [AW-1:0] ra [NCH];
  logic [CW-1:0] rc [NCH];
  logic [3:0]    rctl [NCH];
  logic [NCH*AW-1:0] ch_addr;
  logic [NCH*CW-1:0] ch_count;
  logic [NCH*4-1:0]  ch_ctrl;

  logic bus_req_tsc, bus_req_halt, ack_valid, mem_wr, mem_rd, dev_rd, dev_wr, done;
  logic [1:0] ack_chan;
  logic [AW-1:0] mem_addr, upd_addr;
  logic [CW-1:0] upd_count;

  logic cfg_we = 1'b0;
  int   cfg_ch = 0;
  logic [AW-1:0] cfg_a = '0;
  logic [CW-1:0] cfg_c = '0;
  logic [3:0]    cfg_ctl = '0;
  logic [NCH-1:0] set_mask = '0, clr_mask = '0;

  int checks = 0, errors = 0;
  int nbytes [NCH];
  int order [16];
  int nord = 0;
  int cyc = 0;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_addr[i*AW +: AW]  = ra[i];
      ch_count[i*CW +: CW] = rc[i];
      ch_ctrl[i*4 +: 4]    = rctl[i];
    end
  end

  dma_seq #(.NCH(NCH), .AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rotate(rotate), .xfer_req(req),
    .grant(grant), .ch_addr(ch_addr), .ch_count(ch_count), .ch_ctrl(ch_ctrl),
    .bus_req_tsc(bus_req_tsc), .bus_req_halt(bus_req_halt), .ack_valid(ack_valid),
    .ack_chan(ack_chan), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .upd_addr(upd_addr), .upd_count(upd_count),
    .done(done)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_step(logic [AW-1:0] a, logic down);
    return down ? a - 1'b1 : a + 1'b1;
  endfunction

  // channel register file and request lines, as the surrounding logic would hold them
  always @(posedge clk) begin
    logic [NCH-1:0] r;
    if (!rst_n) req <= '0;
    else begin
      r = (req | set_mask) & ~clr_mask;
      if (ack_valid) begin
        ra[ack_chan] <= upd_addr;
        rc[ack_chan] <= upd_count;
        if (done) r[ack_chan] = 1'b0;
      end
      req <= r;
    end
    if (cfg_we) begin
      ra[cfg_ch]   <= cfg_a;
      rc[cfg_ch]   <= cfg_c;
      rctl[cfg_ch] <= cfg_ctl;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(!(bus_req_tsc && bus_req_halt), "R5 one request line", {bus_req_tsc, bus_req_halt}, 0);
    if (ack_valid) begin
      logic d;
      d = rctl[ack_chan][0];
      chk(grant && req[ack_chan], "R6 grant and request", {grant, req[ack_chan]}, 3);
      chk(mem_addr == ra[ack_chan], "R7 address", mem_addr, ra[ack_chan]);
      chk({mem_wr, dev_rd, mem_rd, dev_wr} == {!d, !d, d, d}, "R7 strobes",
          {mem_wr, dev_rd, mem_rd, dev_wr}, {!d, !d, d, d});
      chk(upd_addr == exp_step(ra[ack_chan], rctl[ack_chan][3]), "R8 address step",
          upd_addr, exp_step(ra[ack_chan], rctl[ack_chan][3]));
      chk(upd_count == rc[ack_chan] - 1'b1, "R8 count", upd_count, rc[ack_chan] - 1'b1);
      chk(done == (rc[ack_chan] == 1), "R9 done", done, (rc[ack_chan] == 1));
      nbytes[ack_chan]++;
      if (done && nord < 16) begin order[nord] = ack_chan; nord++; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg(int ch, logic [AW-1:0] a, logic [CW-1:0] c, logic [3:0] ctl);
    cfg_ch = ch; cfg_a = a; cfg_c = c; cfg_ctl = ctl; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic set_req(logic [NCH-1:0] m);
    set_mask = m; tick(); set_mask = '0;
  endtask

  task automatic clr_req(logic [NCH-1:0] m);
    clr_mask = m; tick(); clr_mask = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; grant = 1'b0; chan_en = '0;
    tick(); tick();
    rst_n = 1'b1;
    nord = 0;
    for (int i = 0; i < NCH; i++) nbytes[i] = 0;
    tick();
  endtask

  task automatic wait_nord(int n);
    for (int i = 0; i < 200 && nord < n; i++) tick();
  endtask

  task automatic mode_case(logic [1:0] m, logic dir, logic down);
    logic av [24], hv [24], tv [24], dn [24];
    int n;
    grant = 1'b0;
    cfg(0, 16'h2000, 3, {down, m, dir});
    chan_en = 4'b0001;
    set_req(4'b0001);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (bus_req_halt || bus_req_tsc) break;
    end
    chk({bus_req_halt, bus_req_tsc} == {m == 2'b00 || m == 2'b01, m == 2'b10},
        "R5 line by mode", {bus_req_halt, bus_req_tsc}, {m == 2'b00 || m == 2'b01, m == 2'b10});
    tick();
    grant = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      av[i] = ack_valid; hv[i] = bus_req_halt; tv[i] = bus_req_tsc; dn[i] = done;
    end
    tick();
    grant = 1'b0;
    n = 0;
    for (int i = 0; i < 24; i++) if (av[i]) n++;
    chk(n == 3, "R8 byte total", n, 3);
    for (int i = 0; i < 23; i++) if (av[i]) begin
      if (dn[i]) chk(!hv[i+1] && !tv[i+1], "R9 release", {hv[i+1], tv[i+1]}, 0);
      else case (m)
        2'b00: chk(!hv[i+1], "R10 halt drop", hv[i+1], 0);
        2'b10: chk(!tv[i+1], "R10 tsc drop", tv[i+1], 0);
        2'b01: chk(av[i+1] && hv[i+1], "R10 block burst", {av[i+1], hv[i+1]}, 3);
        default: chk(!av[i+1] && !hv[i+1] && !tv[i+1], "R11 undefined mode",
                     {av[i+1], hv[i+1], tv[i+1]}, 0);
      endcase
    end
    chk(req[0] == 1'b0, "R9 channel finished", req[0], 0);
  endtask

  task automatic prio_case(logic rot);
    do_reset();
    rotate = rot;
    for (int i = 0; i < NCH; i++) cfg(i, 16'h0100 * i, 1, 4'b0010);
    chan_en = 4'b1111;
    grant = 1'b1;
    set_req(4'b0100);
    wait_nord(1);
    set_req(4'b1011);
    wait_nord(4);
    grant = 1'b0;
    if (rot) begin
      chk(order[1] == 3 && order[2] == 0 && order[3] == 1, "R3 rotating order",
          {order[1][7:0], order[2][7:0], order[3][7:0]}, 24'h030001);
    end else begin
      chk(order[1] == 0 && order[2] == 1 && order[3] == 3, "R2 fixed order",
          {order[1][7:0], order[2][7:0], order[3][7:0]}, 24'h000103);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NCH; i++) begin ra[i] = '0; rc[i] = '0; rctl[i] = '0; nbytes[i] = 0; end
    tick(); tick();
    @(negedge clk);
    chk({bus_req_tsc, bus_req_halt, ack_valid, done, mem_wr, mem_rd, dev_rd, dev_wr} == 0,
        "R1 outputs in reset", {bus_req_tsc, bus_req_halt, ack_valid, done}, 0);
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    chk({bus_req_tsc, bus_req_halt, ack_valid, done, mem_wr, mem_rd, dev_rd, dev_wr} == 0,
        "R1 outputs after reset", {bus_req_tsc, bus_req_halt, ack_valid, done}, 0);
    tick();

    mode_case(2'b00, 1'b0, 1'b0);
    mode_case(2'b01, 1'b1, 1'b1);
    mode_case(2'b10, 1'b0, 1'b1);
    mode_case(2'b11, 1'b1, 1'b0);

    prio_case(1'b0);
    prio_case(1'b1);

    // R4: zero count and disabled channel hold the machine back
    do_reset();
    cfg(1, 16'h4000, 0, 4'b0000);
    chan_en = 4'b0010;
    grant = 1'b1;
    set_req(4'b0010);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (bus_req_halt || bus_req_tsc || ack_valid) seen++;
      end
      chk(seen == 0, "R4 zero count holds", seen, 0);
      tick();
      chan_en = 4'b0000;
      cfg(1, 16'h4000, 2, 4'b0000);
      seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (bus_req_halt || bus_req_tsc || ack_valid) seen++;
      end
      chk(seen == 0, "R4 disabled holds", seen, 0);
      tick();
      chan_en = 4'b0010;
      for (int i = 0; i < 40 && req[1]; i++) tick();
      chk(nbytes[1] == 2, "R4 proceeds once ready", nbytes[1], 2);
    end

    // R6: grant and request gating
    do_reset();
    cfg(2, 16'h8000, 2, 4'b0000);
    chan_en = 4'b0100;
    set_req(4'b0100);
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (ack_valid) seen++; end
      chk(seen == 0 && bus_req_halt, "R6 no grant no byte", {seen[7:0], bus_req_halt}, 1);
      tick();
      clr_req(4'b0100);
      grant = 1'b1;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (ack_valid) seen++; end
      chk(seen == 0, "R6 no request no byte", seen, 0);
      tick();
      set_req(4'b0100);
      for (int i = 0; i < 20 && req[2]; i++) tick();
      chk(nbytes[2] == 2, "R6 resumes", nbytes[2], 2);
      grant = 1'b0;
    end

    // random rounds
    for (int r = 0; r < 30; r++) begin
      logic [NCH-1:0] m;
      int cnt [NCH];
      do_reset();
      rotate = 1'($urandom);
      for (int c = 0; c < NCH; c++) begin
        cnt[c] = 1 + ($urandom % 5);
        cfg(c, 16'($urandom), 16'(cnt[c]), 4'($urandom));
      end
      m = 4'($urandom);
      if (m == 0) m = 4'b1000;
      chan_en = 4'b1111;
      set_req(m);
      for (int i = 0; i < 2000 && req != 0; i++) begin
        grant = ($urandom % 4) != 0;
        tick();
      end
      grant = 1'b0;
      for (int c = 0; c < NCH; c++)
        chk(nbytes[c] == (m[c] ? cnt[c] : 0), "R8 random byte total", nbytes[c], m[c] ? cnt[c] : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule